// File: doc/BRIEF.md
# DMA Missed-Event Error Tracker

This block watches the trigger traffic of a 32-channel DMA channel controller and records, per channel, when a trigger was lost. Each channel holds three independent pending flags, one per trigger kind: hardware event, software (manual) trigger and chain trigger. A trigger sets the pending flag of its kind, and a service strobe of the same kind clears it. When a trigger of a given kind arrives while that kind's flag is still pending, the channel's missed bit is latched. A null-transfer indication from the servicing logic also latches the missed bit of that channel.

Software reads the missed bits from a read-only status register. It clears them by writing ones to a separate clear register. Errors from elsewhere in the controller arrive on a single summary input. The block raises a one-cycle error interrupt pulse only when the combined error state goes from fully clear to not clear.

Top module: `dma_miss_tracker`

## Requirements
- R1: After reset every missed bit reads 0 and the interrupt output is low.
- R2: A hardware trigger on channel n while channel n's hardware pending flag is set latches missed bit n, which is bit n of the status register at byte offset 0.
- R3: Trigger kinds are tracked apart. A software or chain trigger does not count as a miss against a pending hardware trigger, and the reverse also holds. A second software trigger, or a second chain trigger, against its own pending flag latches the missed bit.
- R4: A service strobe clears the pending flag of its kind, so a later trigger of that kind is not a miss. A trigger that lands in the same cycle as the service strobe leaves the flag pending and records no miss.
- R5: A null-transfer indication on channel n latches missed bit n.
- R6: A missed bit clears only when a 1 is written to the same bit of the clear register at byte offset 4. Writing 0 there, or writing anything to offset 0, changes nothing.
- R7: The clear register always reads as zero.
- R8: When a set condition and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R9: The interrupt is a single-cycle pulse. It fires when a missed bit sets while no missed bit and no summary error was set before. It does not fire again while any error stays set.
- R10: The summary error input is part of the error state. Its rise from an all-clear state pulses the interrupt, and while it is high a new miss raises no interrupt.
- R11: Misses on several channels, from different trigger kinds, in the same cycle all latch independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwSet | input | 32 | Hardware event trigger, one bit per channel |
| hwSvc | input | 32 | Hardware event pending flag service clear |
| swSet | input | 32 | Software trigger, one bit per channel |
| swSvc | input | 32 | Software trigger service clear |
| chSet | input | 32 | Chain trigger, one bit per channel |
| chSvc | input | 32 | Chain trigger service clear |
| nullHit | input | 32 | Null transfer found while servicing a channel |
| otherErr | input | 1 | Summary of all other error sources |
| regAddr | input | 4 | Register byte address |
| regWe | input | 1 | Register write enable |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| errIrq | output | 1 | Error interrupt pulse |

## Verification
The missed bits, the pending flags and the interrupt are all registered. Each of them shows the effect of a stimulus after exactly one rising clock edge, and read data follows the address within the same cycle. The bench drives each stimulus just after a falling edge and holds it across one rising edge. It samples status and interrupt just after the next falling edge, so every check lands in the first cycle a result is due. The one-cycle width of the interrupt is checked by sampling again one cycle later.

// File: rtl/dma_miss_pkg.sv
package dma_miss_pkg;

  // Trigger kinds, in the order their pending flags are stacked
  typedef enum logic [1:0] {
    SRC_HW    = 2'd0,
    SRC_SW    = 2'd1,
    SRC_CHAIN = 2'd2
  } srcKind_e;

  localparam int NUM_SRC = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrWe;    // write hit on the clear register
    logic statSel;  // address selects the status register
  } regStrobe_t;

endpackage

// File: rtl/miss_datapath.sv
module miss_datapath
  import dma_miss_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_SRC-1:0][NUM_CH-1:0]   trigSet,
  input  logic [NUM_SRC-1:0][NUM_CH-1:0]   trigSvc,
  input  logic [NUM_CH-1:0]                nullHit,
  input  regStrobe_t                       strobe,
  input  logic [NUM_CH-1:0]                clrBits,
  output logic [NUM_CH-1:0]                missVec,
  output logic                             missNextAny
);

  logic [NUM_SRC-1:0][NUM_CH-1:0] pendQ;
  logic [NUM_SRC-1:0][NUM_CH-1:0] hitMiss;
  logic [NUM_CH-1:0]              missSrc;
  logic [NUM_CH-1:0]              clrMask;
  logic [NUM_CH-1:0]              missQ;
  logic [NUM_CH-1:0]              missNext;

  // One bank of pending flags per trigger kind
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    // Retrigger on a pending flag that is not being serviced this cycle
    assign hitMiss[s] = trigSet[s] & pendQ[s] & ~trigSvc[s];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendQ[s] <= '0;
      else       pendQ[s] <= (pendQ[s] & ~trigSvc[s]) | trigSet[s];
    end
  end

  always_comb begin
    missSrc = nullHit;
    for (int s = 0; s < NUM_SRC; s++) missSrc = missSrc | hitMiss[s];
  end

  assign clrMask  = strobe.clrWe ? clrBits : '0;
  // New misses take priority over a same-cycle clear
  assign missNext = (missQ & ~clrMask) | missSrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) missQ <= '0;
    else       missQ <= missNext;
  end

  assign missVec     = missQ;
  assign missNextAny = |missNext;

endmodule

// File: rtl/miss_ctrl.sv
module miss_ctrl
  import dma_miss_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 0,
  parameter int CLR_OFS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              missNextAny,
  input  logic              otherErr,
  output regStrobe_t        strobe,
  output logic              errIrq
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] CLR_ADDR  = ADDR_W'(CLR_OFS);

  logic errNext;
  logic errQ;
  logic irqQ;

  always_comb begin
    strobe.statSel = (regAddr == STAT_ADDR);
    strobe.clrWe   = regWe && (regAddr == CLR_ADDR);
  end

  assign errNext = missNextAny | otherErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= 1'b0;
      irqQ <= 1'b0;
    end else begin
      errQ <= errNext;
      irqQ <= errNext & ~errQ;
    end
  end

  assign errIrq = irqQ;

endmodule

// File: rtl/dma_miss_tracker.sv
module dma_miss_tracker
  import dma_miss_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 0,
  parameter int CLR_OFS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] hwSet,
  input  logic [NUM_CH-1:0] hwSvc,
  input  logic [NUM_CH-1:0] swSet,
  input  logic [NUM_CH-1:0] swSvc,
  input  logic [NUM_CH-1:0] chSet,
  input  logic [NUM_CH-1:0] chSvc,
  input  logic [NUM_CH-1:0] nullHit,
  input  logic              otherErr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              errIrq
);

  logic [NUM_SRC-1:0][NUM_CH-1:0] trigSet;
  logic [NUM_SRC-1:0][NUM_CH-1:0] trigSvc;
  regStrobe_t                     strobe;
  logic [NUM_CH-1:0]              missVec;
  logic                           missNextAny;

  always_comb begin
    trigSet[SRC_HW]    = hwSet;
    trigSet[SRC_SW]    = swSet;
    trigSet[SRC_CHAIN] = chSet;
    trigSvc[SRC_HW]    = hwSvc;
    trigSvc[SRC_SW]    = swSvc;
    trigSvc[SRC_CHAIN] = chSvc;
  end

  miss_ctrl #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .CLR_OFS (CLR_OFS)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWe      (regWe),
    .missNextAny(missNextAny),
    .otherErr   (otherErr),
    .strobe     (strobe),
    .errIrq     (errIrq)
  );

  miss_datapath #(
    .NUM_CH(NUM_CH)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .trigSet    (trigSet),
    .trigSvc    (trigSvc),
    .nullHit    (nullHit),
    .strobe     (strobe),
    .clrBits    (regWdata[NUM_CH-1:0]),
    .missVec    (missVec),
    .missNextAny(missNextAny)
  );

  // Clear register and unmapped offsets read as zero
  assign regRdata = strobe.statSel ? DATA_W'(missVec) : '0;

endmodule

// File: rtl/dma_miss_checker.sv
module dma_miss_checker #(
  parameter int NUM_CH  = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int CLR_OFS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] nullHit,
  input logic              otherErr,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [DATA_W-1:0] regRdata,
  input logic              errIrq,
  input logic [NUM_CH-1:0] missVec
);

  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(CLR_OFS);

  p_null_marks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|nullHit) |=> ((missVec & $past(nullHit)) == $past(nullHit)));

  p_fall_needs_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(missVec) & ~missVec)) |-> ($past(regWe) && ($past(regAddr) == CLR_ADDR)));

  p_clear_reads_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CLR_ADDR) |-> (regRdata == '0));

  // R8: a null hit under a same-cycle clear write still leaves its bit set
  p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && (regAddr == CLR_ADDR) && (|nullHit)) |=> ((missVec & $past(nullHit)) != '0));

  p_irq_one_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |=> !errIrq);

  p_irq_from_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> ($past(missVec) == '0));

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(otherErr) && otherErr && $past(otherErr, 2)) |-> !errIrq);

endmodule

bind dma_miss_tracker dma_miss_checker #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .CLR_OFS(CLR_OFS)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .nullHit (nullHit),
  .otherErr(otherErr),
  .regAddr (regAddr),
  .regWe   (regWe),
  .regRdata(regRdata),
  .errIrq  (errIrq),
  .missVec (missVec)
);

// File: tb/dma_miss_tracker_tb.sv
module dma_miss_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] hwSet = '0, hwSvc = '0, swSet = '0, swSvc = '0;
  logic [31:0] chSet = '0, chSvc = '0, nullHit = '0;
  logic        otherErr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        errIrq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_miss_tracker dut_i (
    .clk(clk), .rstN(rstN),
    .hwSet(hwSet), .hwSvc(hwSvc), .swSet(swSet), .swSvc(swSvc),
    .chSet(chSet), .chSvc(chSvc), .nullHit(nullHit), .otherErr(otherErr),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .errIrq(errIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Cross one rising edge, land just after the falling edge
  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idleInputs();
    hwSet = '0; hwSvc = '0; swSet = '0; swSvc = '0;
    chSet = '0; chSvc = '0; nullHit = '0;
    regWe = 1'b0; regAddr = 4'd0; regWdata = '0;
  endtask

  task automatic readStat(output logic [31:0] v);
    regWe = 1'b0;
    regAddr = 4'd0;
    #1;
    v = regRdata;
  endtask

  task automatic cleanAll();
    idleInputs();
    otherErr = 1'b0;
    hwSvc = '1; swSvc = '1; chSvc = '1;
    regAddr = 4'd4; regWe = 1'b1; regWdata = '1;
    tick();
    idleInputs();
    tick();
  endtask

  task automatic testReset();
    logic [31:0] v;
    readStat(v);
    chk("R1 status", v, 32'h0);
    chk("R1 irq", {31'b0, errIrq}, 32'h0);
  endtask

  task automatic testHw();
    logic [31:0] v;
    cleanAll();
    hwSet = 32'h1 << 5; tick(); idleInputs();
    readStat(v);
    chk("R2 first trigger no miss", v, 32'h0);
    hwSet = 32'h1 << 5; tick(); idleInputs();
    readStat(v);
    chk("R2 retrigger miss", v, 32'h0000_0020);
    chk("R9 irq pulse", {31'b0, errIrq}, 32'h1);
    tick();
    chk("R9 irq one cycle", {31'b0, errIrq}, 32'h0);
  endtask

  task automatic testKinds();
    logic [31:0] v;
    cleanAll();
    hwSet = 32'h8; tick(); idleInputs();
    swSet = 32'h8; tick(); idleInputs();
    chSet = 32'h8; tick(); idleInputs();
    readStat(v);
    chk("R3 kinds separate", v, 32'h0);
    swSet = 32'h8; tick(); idleInputs();
    readStat(v);
    chk("R3 sw retrigger", v, 32'h8);
    chSet = 32'h200; tick(); idleInputs();
    chSet = 32'h200; tick(); idleInputs();
    readStat(v);
    chk("R3 chain retrigger", v, 32'h208);
  endtask

  task automatic testSvc();
    logic [31:0] v;
    cleanAll();
    hwSet = 32'h2; tick(); idleInputs();
    hwSvc = 32'h2; tick(); idleInputs();
    hwSet = 32'h2; tick(); idleInputs();
    readStat(v);
    chk("R4 serviced no miss", v, 32'h0);
    hwSet = 32'h2; hwSvc = 32'h2; tick(); idleInputs();
    readStat(v);
    chk("R4 collide no miss", v, 32'h0);
    hwSet = 32'h2; tick(); idleInputs();
    readStat(v);
    chk("R4 collide keeps pending", v, 32'h2);
  endtask

  task automatic testNullClear();
    logic [31:0] v;
    cleanAll();
    nullHit = 32'h4000_0004; tick(); idleInputs();
    readStat(v);
    chk("R5 null miss", v, 32'h4000_0004);
    regAddr = 4'd4; regWe = 1'b1; regWdata = 32'h0; tick(); idleInputs();
    readStat(v);
    chk("R6 write zero no effect", v, 32'h4000_0004);
    regAddr = 4'd0; regWe = 1'b1; regWdata = '1; tick(); idleInputs();
    readStat(v);
    chk("R6 status write ignored", v, 32'h4000_0004);
    regAddr = 4'd4; regWe = 1'b0; #1;
    chk("R7 clear reads zero", regRdata, 32'h0);
    regAddr = 4'd4; regWe = 1'b1; regWdata = 32'h4000_0000; tick(); idleInputs();
    readStat(v);
    chk("R6 write one clears", v, 32'h0000_0004);
  endtask

  task automatic testSetWins();
    logic [31:0] v;
    cleanAll();
    nullHit = 32'h80; tick(); idleInputs();
    nullHit = 32'h80; regAddr = 4'd4; regWe = 1'b1; regWdata = 32'h80;
    tick(); idleInputs();
    readStat(v);
    chk("R8 set beats clear", v, 32'h80);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    cleanAll();
    nullHit = 32'h1; tick(); idleInputs();
    chk("R9 irq on first error", {31'b0, errIrq}, 32'h1);
    tick();
    nullHit = 32'h2; tick(); idleInputs();
    chk("R9 no irq while error held", {31'b0, errIrq}, 32'h0);
    readStat(v);
    chk("R9 both bits", v, 32'h3);
    cleanAll();
    nullHit = 32'h10; tick(); idleInputs();
    chk("R9 irq again after clear", {31'b0, errIrq}, 32'h1);
  endtask

  task automatic testOther();
    logic [31:0] v;
    cleanAll();
    otherErr = 1'b1; tick();
    chk("R10 summary rise irq", {31'b0, errIrq}, 32'h1);
    tick();
    chk("R10 summary irq one cycle", {31'b0, errIrq}, 32'h0);
    nullHit = 32'h40; tick(); idleInputs();
    chk("R10 masked by summary", {31'b0, errIrq}, 32'h0);
    readStat(v);
    chk("R10 bit still latched", v, 32'h40);
    cleanAll();
    nullHit = 32'h40; tick(); idleInputs();
    chk("R10 irq after summary clear", {31'b0, errIrq}, 32'h1);
  endtask

  task automatic testMulti();
    logic [31:0] v;
    cleanAll();
    hwSet = 32'h0000_00F0; chSet = 32'h8000_0000; swSet = 32'h0001_0000;
    tick(); idleInputs();
    hwSet = 32'h0000_00F0; chSet = 32'h8000_0000; swSet = 32'h0001_0000;
    nullHit = 32'h0000_1000;
    tick(); idleInputs();
    readStat(v);
    chk("R11 many channels", v, 32'h8001_10F0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idleInputs();
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testHw();
    testKinds();
    testSvc();
    testNullClear();
    testSetWins();
    testIrq();
    testOther();
    testMulti();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule